// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash with a 17-bit byte address. It watches a synchronous write strobe that carries an address and a data byte, and it recognises the keyed command sequences. Each sequence opens with a two-write unlock on fixed address/data pairs. The third write, at the key address, selects the command. For the erase commands, a second unlock pair has to come before the final write.

For each command it accepts, the block raises a one-cycle pulse. The pulse carries a command kind, together with the address and data that the command needs. The block also keeps a mode flag that tells the read path whether to return array data or identification codes. Program and erase pulses are held back while an erase is already running, or when they aim at the lockable boot region and the lock input is set. The storage array, the operation timers and the high-voltage detection are outside this block. The lock condition and the busy condition arrive here as plain digital inputs.

Top module: `fcsd_top`

## Requirements
- R1: An unlock pair is data AAh at a key address ending in 5555h followed by data 55h at a key address ending in 2AAAh. Only address bits 14:0 are compared, so bits 16:15 do not matter for key addresses.
- R2: After an unlock pair, a write of 90h at the 5555h key address raises a pulse of kind 2 (autoselect) and sets `id_mode` to 1. `id_mode` changes only in the cycle after a write.
- R3: A write of F0h at any address, in any sequencer state except while waiting for program data, raises a pulse of kind 1 (read reset). It clears `id_mode` to 0 and returns the sequencer to idle. This also applies when F0h is written as the third write of an unlocked sequence.
- R4: After an unlock pair, a write of A0h at 5555h makes the next write, whatever its address and data, raise a pulse of kind 3 (program). That pulse carries the address and data of this next write.
- R5: After an unlock pair, 80h at 5555h, and a second unlock pair, two sixth writes are accepted. A write of 10h at 5555h raises kind 4 (chip erase) with address 0 and data 0. A write of 30h at any address raises kind 5 (sector erase) with that address and data 0; the sector is address bits 16:9.
- R6: A write that does not fit the expected pattern raises no pulse and returns the sequencer to idle. That write is not reused as the start of a new sequence.
- R7: A program pulse is suppressed when `erase_busy` is high in the cycle of the data write. The sequencer still returns to idle.
- R8: When `boot_lock` is high, two things are suppressed. A program or sector erase whose address lies in the boot region gives no pulse. A chip erase gives no pulse at all. The boot region is 1E000h–1FFFFh when TOP_BOOT=1 and 00000h–01FFFh when TOP_BOOT=0.
- R9: `cmd_valid` is high for exactly the one cycle after the clock edge that takes the completing write. While it is low, `cmd_kind`, `cmd_addr` and `cmd_data` are 0.
- R10: A synchronous active-high reset drives `cmd_valid` low and `id_mode` to 0, and puts the sequencer in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| erase_busy | input | 1 | An erase operation is in progress |
| boot_lock | input | 1 | Boot region is locked |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_kind | output | 3 | 1 read reset, 2 autoselect, 3 program, 4 chip erase, 5 sector erase |
| cmd_addr | output | 17 | Target address of the command |
| cmd_data | output | 8 | Program data byte |
| id_mode | output | 1 | 1 = identification read mode, 0 = array read |

## Verification
The assertions assume that `erase_busy` and `boot_lock` are sampled on the same clock edge as the write they qualify. They also assume that every input is a known value once reset is released. The stimulus meets both conditions by changing all inputs only at the falling clock edge and by holding reset from time zero. Random writes are drawn mostly from the key addresses and command bytes, with occasional full legal sequences mixed in, so that broken sequences, late F0h writes, and boot-region targets with the lock set or clear all occur often.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PDATA,
    SQ_ESETUP,
    SQ_EKEY1,
    SQ_EKEY2
  } seq_t;

  typedef enum logic [2:0] {
    CK_NONE   = 3'd0,
    CK_READ   = 3'd1,
    CK_IDENT  = 3'd2,
    CK_PROG   = 3'd3,
    CK_CHIP   = 3'd4,
    CK_SECTOR = 3'd5
  } cmd_kind_t;

  localparam logic [7:0] OP_KEY1   = 8'hAA;
  localparam logic [7:0] OP_KEY2   = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ESETUP = 8'h80;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_READ   = 8'hF0;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SECTOR = 8'h30;

endpackage

// File: rtl/fcsd_match.sv
module fcsd_match #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int KEY_BITS = 15,
  parameter logic [KEY_BITS-1:0] KEY_A = 15'h5555,
  parameter logic [KEY_BITS-1:0] KEY_B = 15'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              at_key_a,
  output logic              unlock_a,
  output logic              unlock_b,
  output logic              op_prog,
  output logic              op_esetup,
  output logic              op_ident,
  output logic              op_read,
  output logic              op_chip,
  output logic              op_sector
);
  import fcsd_pkg::*;

  logic at_key_b;

  function automatic logic key_hit(input logic [ADDR_W-1:0] a,
                                   input logic [KEY_BITS-1:0] k);
    return a[KEY_BITS-1:0] == k;
  endfunction

  always_comb begin
    at_key_a  = key_hit(addr, KEY_A);
    at_key_b  = key_hit(addr, KEY_B);
    unlock_a  = at_key_a && (data == OP_KEY1);
    unlock_b  = at_key_b && (data == OP_KEY2);
    op_prog   = at_key_a && (data == OP_PROG);
    op_esetup = at_key_a && (data == OP_ESETUP);
    op_ident  = at_key_a && (data == OP_IDENT);
    op_chip   = at_key_a && (data == OP_CHIP);
    op_read   = (data == OP_READ);
    op_sector = (data == OP_SECTOR);
  end

endmodule

// File: rtl/fcsd_seq.sv
module fcsd_seq (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                unlock_a,
  input  logic                unlock_b,
  input  logic                op_prog,
  input  logic                op_esetup,
  input  logic                op_ident,
  input  logic                op_read,
  input  logic                op_chip,
  input  logic                op_sector,
  output fcsd_pkg::seq_t      state,
  output fcsd_pkg::cmd_kind_t raw_kind
);
  import fcsd_pkg::*;

  seq_t nxt;

  always_comb begin
    nxt      = state;
    raw_kind = CK_NONE;
    if (wr_en) begin
      nxt = SQ_IDLE;
      if (state == SQ_PDATA) begin
        raw_kind = CK_PROG;
      end else if (op_read) begin
        raw_kind = CK_READ;
      end else begin
        case (state)
          SQ_IDLE:   if (unlock_a) nxt = SQ_KEY1;
          SQ_KEY1:   if (unlock_b) nxt = SQ_KEY2;
          SQ_KEY2: begin
            if (op_prog)        nxt = SQ_PDATA;
            else if (op_esetup) nxt = SQ_ESETUP;
            else if (op_ident)  raw_kind = CK_IDENT;
          end
          SQ_ESETUP: if (unlock_a) nxt = SQ_EKEY1;
          SQ_EKEY1:  if (unlock_b) nxt = SQ_EKEY2;
          SQ_EKEY2: begin
            if (op_chip)        raw_kind = CK_CHIP;
            else if (op_sector) raw_kind = CK_SECTOR;
          end
          default: nxt = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= nxt;
  end

endmodule

// File: rtl/fcsd_gate.sv
module fcsd_gate #(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int SECT_BITS    = 8,
  parameter int BOOT_SECTORS = 16,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  fcsd_pkg::cmd_kind_t raw_kind,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   data,
  input  logic                erase_busy,
  input  logic                boot_lock,
  output logic                blocked,
  output logic                cmd_valid,
  output logic [2:0]          cmd_kind,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [DATA_W-1:0]   cmd_data,
  output logic                id_mode
);
  import fcsd_pkg::*;

  localparam int NUM_SECT = 1 << SECT_BITS;
  localparam int BOOT_LO  = TOP_BOOT ? NUM_SECT - BOOT_SECTORS : 0;
  localparam int BOOT_HI  = TOP_BOOT ? NUM_SECT - 1 : BOOT_SECTORS - 1;

  function automatic logic [SECT_BITS-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_BITS];
  endfunction

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    int s;
    s = int'(sector_of(a));
    return (s >= BOOT_LO) && (s <= BOOT_HI);
  endfunction

  logic busy_stop, lock_stop, take;

  always_comb begin
    busy_stop = (raw_kind == CK_PROG) && erase_busy;
    lock_stop = boot_lock &&
                ((raw_kind == CK_CHIP) ||
                 (((raw_kind == CK_PROG) || (raw_kind == CK_SECTOR)) && in_boot(addr)));
    blocked   = busy_stop || lock_stop;
    take      = (raw_kind != CK_NONE) && !blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_kind  <= 3'd0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      id_mode   <= 1'b0;
    end else begin
      cmd_valid <= take;
      cmd_kind  <= take ? raw_kind : 3'd0;
      cmd_addr  <= (take && (raw_kind == CK_PROG || raw_kind == CK_SECTOR)) ? addr : '0;
      cmd_data  <= (take && raw_kind == CK_PROG) ? data : '0;
      if (raw_kind == CK_IDENT)     id_mode <= 1'b1;
      else if (raw_kind == CK_READ) id_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/fcsd_top.sv
module fcsd_top #(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int SECT_BITS    = 8,
  parameter int KEY_BITS     = 15,
  parameter int BOOT_SECTORS = 16,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  input  logic              boot_lock,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_mode
);
  import fcsd_pkg::*;

  logic      at_key_a, unlock_a, unlock_b;
  logic      op_prog, op_esetup, op_ident, op_read, op_chip, op_sector;
  seq_t      seq_state;
  cmd_kind_t raw_kind;
  logic      blocked;

  fcsd_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_BITS(KEY_BITS)
  ) u_match (
    .addr(wr_addr), .data(wr_data),
    .at_key_a(at_key_a), .unlock_a(unlock_a), .unlock_b(unlock_b),
    .op_prog(op_prog), .op_esetup(op_esetup), .op_ident(op_ident),
    .op_read(op_read), .op_chip(op_chip), .op_sector(op_sector)
  );

  fcsd_seq u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .unlock_a(unlock_a), .unlock_b(unlock_b),
    .op_prog(op_prog), .op_esetup(op_esetup), .op_ident(op_ident),
    .op_read(op_read), .op_chip(op_chip), .op_sector(op_sector),
    .state(seq_state), .raw_kind(raw_kind)
  );

  fcsd_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
    .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(TOP_BOOT)
  ) u_gate (
    .clk(clk), .rst(rst), .raw_kind(raw_kind),
    .addr(wr_addr), .data(wr_data),
    .erase_busy(erase_busy), .boot_lock(boot_lock),
    .blocked(blocked),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode)
  );

endmodule

// File: rtl/fcsd_chk.sv
module fcsd_chk #(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int SECT_BITS    = 8,
  parameter int BOOT_SECTORS = 16,
  parameter bit TOP_BOOT     = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              erase_busy,
  input logic              boot_lock,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              id_mode,
  input logic [2:0]        raw_kind,
  input logic              blocked
);
  localparam longint SPAN       = longint'(1) << ADDR_W;
  localparam longint BOOT_BYTES = longint'(BOOT_SECTORS) << (ADDR_W - SECT_BITS);

  function automatic logic boot_addr(input logic [ADDR_W-1:0] a);
    if (TOP_BOOT) return longint'(a) >= SPAN - BOOT_BYTES;
    else          return longint'(a) < BOOT_BYTES;
  endfunction

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_en)); // R9
  AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> (cmd_kind == 3'd0 && cmd_addr == '0 && cmd_data == '0)); // R9
  AST_RAW_REACHES_OUT: assert property (@(posedge clk) disable iff (rst)
    (raw_kind != 3'd0 && !blocked) |=> cmd_valid); // R9
  AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !cmd_valid); // R7
  AST_NO_PROG_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 3'd3) |-> !$past(erase_busy)); // R7
  AST_BOOT_TARGET_GUARD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_kind == 3'd3 || cmd_kind == 3'd5) && $past(boot_lock))
      |-> !boot_addr(cmd_addr)); // R8
  AST_CHIP_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 3'd4) |-> (!$past(boot_lock) && cmd_addr == '0)); // R8
  AST_IDENT_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 3'd2) |-> id_mode); // R2
  AST_READ_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 3'd1) |-> !id_mode); // R3
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(id_mode)); // R2

endmodule

bind fcsd_top fcsd_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS),
  .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(TOP_BOOT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en),
  .erase_busy(erase_busy), .boot_lock(boot_lock),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode),
  .raw_kind(raw_kind), .blocked(blocked)
);

// File: tb/sim_fcsd_top.sv
module sim_fcsd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        erase_busy = 1'b0;
  logic        boot_lock = 1'b0;

  logic        v0, v1, m0, m1;
  logic [2:0]  k0, k1;
  logic [16:0] a0, a1;
  logic [7:0]  d0, d1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  fcsd_top #(.TOP_BOOT(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_busy(erase_busy), .boot_lock(boot_lock),
    .cmd_valid(v0), .cmd_kind(k0), .cmd_addr(a0), .cmd_data(d0), .id_mode(m0));

  fcsd_top #(.TOP_BOOT(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_busy(erase_busy), .boot_lock(boot_lock),
    .cmd_valid(v1), .cmd_kind(k1), .cmd_addr(a1), .cmd_data(d1), .id_mode(m1));

  // reference model: prefix depth of the sequence seen so far
  int   ph   = 0;
  bit   mode = 0;
  bit   ev[2];
  int   ek[2];
  logic [16:0] ea[2];
  logic [7:0]  ed[2];
  string req;

  function automatic bit boot_top(input logic [16:0] a);
    return a >= 17'h1E000;
  endfunction
  function automatic bit boot_bot(input logic [16:0] a);
    return a <= 17'h01FFF;
  endfunction

  function automatic void model_step(input logic [16:0] a, input logic [7:0] d);
    bit k5 = (a & 17'h07FFF) == 17'h05555;
    bit k2 = (a & 17'h07FFF) == 17'h02AAA;
    int kind = 0;
    int nph  = 0;
    if (ph == 3) kind = 3;
    else if (d == 8'hF0) kind = 1;
    else begin
      if (ph == 0 && k5 && d == 8'hAA) nph = 1;
      if (ph == 1 && k2 && d == 8'h55) nph = 2;
      if (ph == 2 && k5 && d == 8'hA0) nph = 3;
      if (ph == 2 && k5 && d == 8'h80) nph = 4;
      if (ph == 2 && k5 && d == 8'h90) kind = 2;
      if (ph == 4 && k5 && d == 8'hAA) nph = 5;
      if (ph == 5 && k2 && d == 8'h55) nph = 6;
      if (ph == 6 && k5 && d == 8'h10) kind = 4;
      if (ph == 6 && d == 8'h30 && kind == 0) kind = 5;
    end
    ph = nph;
    if (kind == 2) mode = 1;
    if (kind == 1) mode = 0;
    for (int i = 0; i < 2; i++) begin
      bit inb = (i == 0) ? boot_top(a) : boot_bot(a);
      bit ok  = (kind != 0);
      if (kind == 3 && erase_busy) ok = 0;
      if (boot_lock && kind == 4) ok = 0;
      if (boot_lock && (kind == 3 || kind == 5) && inb) ok = 0;
      ev[i] = ok;
      ek[i] = ok ? kind : 0;
      ea[i] = (ok && (kind == 3 || kind == 5)) ? a : 17'h0;
      ed[i] = (ok && kind == 3) ? d : 8'h0;
    end
  endfunction

  task automatic check_one(input int i);
    bit          v = (i == 0) ? v0 : v1;
    logic [2:0]  k = (i == 0) ? k0 : k1;
    logic [16:0] a = (i == 0) ? a0 : a1;
    logic [7:0]  d = (i == 0) ? d0 : d1;
    bit          m = (i == 0) ? m0 : m1;
    n_checks++;
    if (v !== ev[i] || k !== 3'(ek[i]) || a !== ea[i] || d !== ed[i] || m !== mode) begin
      n_fail++;
      $display("FAIL %s u%0d: got v=%0b k=%0d a=%h d=%h m=%0b exp v=%0b k=%0d a=%h d=%h m=%0b",
               req, i, v, k, a, d, m, ev[i], ek[i], ea[i], ed[i], mode);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    model_step(a, d);
    @(negedge clk);
    wr_en = 0;
    check_one(0);
    check_one(1);
  endtask

  task automatic idle();
    for (int i = 0; i < 2; i++) begin ev[i]=0; ek[i]=0; ea[i]='0; ed[i]='0; end
    @(negedge clk);
    check_one(0);
    check_one(1);
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  function automatic logic [16:0] pick_addr();
    case ($urandom % 6)
      0: return 17'h05555;
      1: return 17'h02AAA;
      2: return 17'h15555;
      3: return 17'h1E000 + 17'($urandom % 17'h2000);
      4: return 17'($urandom % 17'h2000);
      default: return 17'($urandom);
    endcase
  endfunction

  function automatic logic [7:0] pick_data();
    case ($urandom % 9)
      0: return 8'hAA; 1: return 8'h55; 2: return 8'hA0; 3: return 8'h80;
      4: return 8'h90; 5: return 8'hF0; 6: return 8'h10; 7: return 8'h30;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    req = "R10";
    for (int i = 0; i < 2; i++) begin ev[i]=0; ek[i]=0; ea[i]='0; ed[i]='0; end
    check_one(0); check_one(1);
    rst = 0;
    idle();

    req = "R2"; unlock(); wr(17'h05555, 8'h90); idle();
    req = "R3"; wr(17'h0ABCD, 8'hF0);
    req = "R1"; wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h05555, 8'h90);
    req = "R3"; unlock(); wr(17'h05555, 8'hF0);
    req = "R4"; unlock(); wr(17'h05555, 8'hA0); wr(17'h01234, 8'hF0);
    req = "R9"; idle();
    req = "R4"; unlock(); wr(17'h05555, 8'hA0); wr(17'h10001, 8'h5A);
    req = "R5"; unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10);
    req = "R5"; unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h0C3F0, 8'h30);
    req = "R6"; wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h90);
    req = "R6"; unlock(); wr(17'h04555, 8'hA0); wr(17'h00010, 8'h11);
    req = "R7"; erase_busy = 1; unlock(); wr(17'h05555, 8'hA0); wr(17'h00020, 8'h22);
    erase_busy = 0; wr(17'h00020, 8'h22);
    req = "R8"; boot_lock = 1;
    unlock(); wr(17'h05555, 8'hA0); wr(17'h1F000, 8'h33);
    unlock(); wr(17'h05555, 8'hA0); wr(17'h00100, 8'h44);
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h1E000, 8'h30);
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10);
    boot_lock = 0; idle();

    req = "R6";
    for (int n = 0; n < 3000; n++) begin
      erase_busy = ($urandom % 4) == 0;
      boot_lock  = ($urandom % 2) == 1;
      if (($urandom % 8) == 0) begin
        unlock();
        case ($urandom % 4)
          0: begin wr(17'h05555, 8'hA0); wr(pick_addr(), pick_data()); end
          1: begin wr(17'h05555, 8'h80); unlock(); wr(pick_addr(), 8'h30); end
          2: begin wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10); end
          default: wr(17'h05555, 8'h90);
        endcase
      end else if (($urandom % 10) == 0) begin
        idle();
      end else begin
        wr(pick_addr(), pick_data());
      end
    end
    erase_busy = 0; boot_lock = 0;

    req = "R10"; rst = 1; @(negedge clk);
    ph = 0; mode = 0;
    for (int i = 0; i < 2; i++) begin ev[i]=0; ek[i]=0; ea[i]='0; ed[i]='0; end
    check_one(0); check_one(1);
    rst = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule